// File: doc/BRIEF.md
# Request Latency Meter with Power-State Snapshot

This block measures how long each mode-change request takes. A one-cycle start pulse opens a measurement and a one-cycle done or timeout pulse closes it. A prescaler divides the clock by a power of two, two to the power of a 5-bit multiplier, so that requests lasting far more than 65,535 cycles can still be expressed in a 16-bit result. The elapsed cycles therefore equal roughly the reported count times two to the power of the multiplier. When the result cannot be held in 16 bits, the count saturates and a flag reports the overrun.

Next to the meter sits a copy of the lanes' power-state word. A select input chooses what the output shows. It can show the live word. It can also show the word frozen at the moment a pending request timed out, so that software can see which lane failed to reach its target state. The word carries one 4-bit group per lane, six lanes in all.

Top module: `req_latency_meter`

## Requirements
- R1: After reset the count output is 0, the overrun flag is 0, and the captured state word is all zeros.
- R2: The start pulse is accepted on clock edge E0, and the done or timeout pulse is present on edge EN, N edges later. From edge EN onward the count shows floor(N / 2^m), where m is the multiplier.
- R3: The multiplier is sampled on the edge that accepts the start pulse. Changes to the multiplier input during the request do not affect that request.
- R4: After done or timeout closes a request, the count and the overrun flag hold until the next start. A done or timeout pulse while no request is open changes neither of them.
- R5: If the count would step beyond 0xFFFF, it stays at 0xFFFF and the overrun flag goes to 1. The flag stays at 1 until the next start pulse clears it. A result of exactly 0xFFFF does not set the flag.
- R6: A start pulse while a request is open restarts the measurement from zero, using the newly sampled multiplier.
- R7: With the select input at 0, the state output equals the live lane word in the same cycle. The word layout is as follows: lane k occupies bits [4k+3:4k], with power state in [4k+1:4k], request at 4k+2 and acknowledge at 4k+3. The lane order is USB receive, USB transmit, then display transmit lanes 0 to 3.
- R8: A timeout pulse that closes an open request captures the live word, and the state output shows that captured word while the select input is 1. A timeout pulse while no request is open leaves the captured word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request accepted (one-cycle pulse) |
| done_i | input | 1 | Request completed (one-cycle pulse) |
| timeout_i | input | 1 | Request timed out (one-cycle pulse) |
| mult_i | input | 5 | Prescale exponent m |
| snap_sel_i | input | 1 | 0: live lane word, 1: word captured at timeout |
| lane_state_i | input | 24 | Live lane power-state word |
| count_o | output | 16 | Prescaled request duration |
| overrun_o | output | 1 | Count saturated |
| state_o | output | 24 | Selected lane power-state word |

## Verification
The bench uses the default parameters: a 16-bit count, a 5-bit multiplier, a 32-bit prescaler and six lanes. Because the count is a full 16 bits, two runs at multiplier 0 are affordable: one of 65,535 cycles and one of 65,536 cycles. Together they cover the exact edge between a full count and an overrun. Multipliers 2, 3 and 5 cover truncation of partial prescale periods, including a request shorter than one period.

// File: rtl/lat_meter_pkg.sv
package lat_meter_pkg;
    // Lane order inside the state word; the index selects the 4-bit group.
    typedef enum logic [2:0] {
        LANE_USB_RX = 3'd0,
        LANE_USB_TX = 3'd1,
        LANE_DP_TX0 = 3'd2,
        LANE_DP_TX1 = 3'd3,
        LANE_DP_TX2 = 3'd4,
        LANE_DP_TX3 = 3'd5
    } lane_idx_e;

    localparam int LANE_NUM   = 6;
    localparam int PSTATE_BITS = 2;
    // Group = pstate, then request, then acknowledge.
    localparam int GROUP_BITS = PSTATE_BITS + 2;
endpackage

// File: rtl/lat_prescaler.sv
module lat_prescaler #(
    parameter int PRE_W  = 32,
    parameter int MULT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              run_i,
    input  logic [MULT_W-1:0] mult_i,
    output logic              tick_o
);
    typedef struct packed {
        logic [PRE_W-1:0] phase;
    } pre_state_t;

    pre_state_t pre_d, pre_q;
    logic [PRE_W-1:0] terminal;

    always_comb begin
        terminal = (PRE_W'(1) << mult_i) - PRE_W'(1);
        tick_o   = run_i && !clear_i && (pre_q.phase == terminal);
        pre_d    = pre_q;
        if (clear_i) begin
            pre_d.phase = '0;
        end else if (run_i) begin
            pre_d.phase = tick_o ? '0 : pre_q.phase + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end
endmodule

// File: rtl/lat_sat_counter.sv
module lat_sat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o,
    output logic             overrun_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] value;
        logic             ovr;
    } cnt_state_t;

    cnt_state_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d.value = '0;
            cnt_d.ovr   = 1'b0;
        end else if (inc_i) begin
            if (cnt_q.value == CNT_MAX) begin
                cnt_d.ovr = 1'b1;
            end else begin
                cnt_d.value = cnt_q.value + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o   = cnt_q.value;
    assign overrun_o = cnt_q.ovr;
endmodule

// File: rtl/lat_state_snap.sv
module lat_state_snap #(
    parameter int LANES  = 6,
    parameter int PST_W  = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           capture_i,
    input  logic                           sel_i,
    input  logic [LANES*(PST_W+2)-1:0]     live_i,
    output logic [LANES*(PST_W+2)-1:0]     state_o
);
    localparam int GRP_W = PST_W + 2;

    typedef struct packed {
        logic             ack;
        logic             req;
        logic [PST_W-1:0] pstate;
    } lane_grp_t;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_grp_t grp_d, grp_q, live_grp;

        always_comb begin
            live_grp = live_i[g*GRP_W +: GRP_W];
            grp_d    = capture_i ? live_grp : grp_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                grp_q <= '0;
            end else begin
                grp_q <= grp_d;
            end
        end

        assign state_o[g*GRP_W +: GRP_W] = sel_i ? grp_q : live_grp;
    end
endmodule

// File: rtl/req_latency_meter.sv
module req_latency_meter #(
    parameter int CNT_W  = 16,
    parameter int MULT_W = 5,
    parameter int PRE_W  = 32,
    parameter int LANES  = lat_meter_pkg::LANE_NUM,
    parameter int PST_W  = lat_meter_pkg::PSTATE_BITS
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic                          done_i,
    input  logic                          timeout_i,
    input  logic [MULT_W-1:0]             mult_i,
    input  logic                          snap_sel_i,
    input  logic [LANES*(PST_W+2)-1:0]    lane_state_i,
    output logic [CNT_W-1:0]              count_o,
    output logic                          overrun_o,
    output logic [LANES*(PST_W+2)-1:0]    state_o
);
    typedef struct packed {
        logic              running;
        logic [MULT_W-1:0] mult;
    } ctl_state_t;

    ctl_state_t ctl_d, ctl_q;
    logic       tick;
    logic       capture;

    always_comb begin
        ctl_d   = ctl_q;
        capture = ctl_q.running && timeout_i && !start_i;
        if (start_i) begin
            ctl_d.running = 1'b1;
            ctl_d.mult    = mult_i;
        end else if (ctl_q.running && (done_i || timeout_i)) begin
            ctl_d.running = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    lat_prescaler #(.PRE_W(PRE_W), .MULT_W(MULT_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (start_i),
        .run_i   (ctl_q.running),
        .mult_i  (ctl_q.mult),
        .tick_o  (tick)
    );

    lat_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (start_i),
        .inc_i     (tick),
        .count_o   (count_o),
        .overrun_o (overrun_o)
    );

    lat_state_snap #(.LANES(LANES), .PST_W(PST_W)) u_snap (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture),
        .sel_i     (snap_sel_i),
        .live_i    (lane_state_i),
        .state_o   (state_o)
    );
endmodule

// File: rtl/req_latency_meter_chk.sv
module req_latency_meter_chk #(
    parameter int CNT_W = 16,
    parameter int SW    = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             done_i,
    input logic             timeout_i,
    input logic             snap_sel_i,
    input logic [SW-1:0]    lane_state_i,
    input logic [CNT_W-1:0] count_o,
    input logic             overrun_o,
    input logic [SW-1:0]    state_o
);
    logic open_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q <= 1'b0;
        end else if (start_i) begin
            open_q <= 1'b1;
        end else if (done_i || timeout_i) begin
            open_q <= 1'b0;
        end
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!open_q && !start_i) |=> ($stable(count_o) && $stable(overrun_o))); // R4

    AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (count_o == '0 && !overrun_o)); // R6

    AST_SAT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |-> (count_o == {CNT_W{1'b1}})); // R5

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_o && !start_i) |=> overrun_o); // R5

    AST_NO_DECREASE: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (count_o >= $past(count_o))); // R2

    AST_LIVE_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_sel_i |-> (state_o == lane_state_i)); // R7
endmodule

bind req_latency_meter req_latency_meter_chk #(
    .CNT_W (CNT_W),
    .SW    (LANES*(PST_W+2))
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .done_i       (done_i),
    .timeout_i    (timeout_i),
    .snap_sel_i   (snap_sel_i),
    .lane_state_i (lane_state_i),
    .count_o      (count_o),
    .overrun_o    (overrun_o),
    .state_o      (state_o)
);

// File: tb/req_latency_meter_test.sv
module req_latency_meter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        done_i = 1'b0;
    logic        timeout_i = 1'b0;
    logic [4:0]  mult_i = '0;
    logic        snap_sel_i = 1'b0;
    logic [23:0] lane_state_i = '0;
    logic [15:0] count_o;
    logic        overrun_o;
    logic [23:0] state_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [15:0] cnt;
        logic        ovr;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    event exp_ev;

    always #2 clk = ~clk;

    req_latency_meter uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .done_i       (done_i),
        .timeout_i    (timeout_i),
        .mult_i       (mult_i),
        .snap_sel_i   (snap_sel_i),
        .lane_state_i (lane_state_i),
        .count_o      (count_o),
        .overrun_o    (overrun_o),
        .state_o      (state_o)
    );

    // Monitor: pops each expected result and compares it with the outputs.
    initial begin
        forever begin
            @(exp_ev);
            #1;
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (count_o !== e.cnt || overrun_o !== e.ovr) begin
                    errors++;
                    $display("FAIL %s: count=%h ovr=%b expected count=%h ovr=%b",
                             e.tag, count_o, overrun_o, e.cnt, e.ovr);
                end
            end
        end
    end

    task automatic expect_result(input logic [15:0] c, input logic o, input string tag);
        exp_t e;
        e.cnt = c;
        e.ovr = o;
        e.tag = tag;
        exp_q.push_back(e);
        -> exp_ev;
        #2;
    endtask

    task automatic check_word(input logic [23:0] exp, input string tag);
        #1;
        checks++;
        if (state_o !== exp) begin
            errors++;
            $display("FAIL %s: state=%h expected %h", tag, state_o, exp);
        end
    endtask

    function automatic logic [16:0] model(input int m, input int n);
        int q;
        q = n >> m;
        if (q > 65535) return {1'b1, 16'hFFFF};
        return {1'b0, q[15:0]};
    endfunction

    // One request: start edge E0, closing pulse on edge En; returns at the negedge after En.
    task automatic run_req(input int m, input int n, input bit by_timeout, input int m_late);
        @(negedge clk);
        start_i = 1'b1;
        mult_i  = 5'(m);
        @(negedge clk);
        start_i = 1'b0;
        mult_i  = 5'(m_late);
        repeat (n - 1) @(negedge clk);
        if (by_timeout) timeout_i = 1'b1; else done_i = 1'b1;
        @(negedge clk);
        done_i = 1'b0;
        timeout_i = 1'b0;
    endtask

    task automatic req_and_check(input int m, input int n, input string tag);
        logic [16:0] r;
        run_req(m, n, 1'b0, m);
        r = model(m, n);
        expect_result(r[15:0], r[16], tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        expect_result(16'h0000, 1'b0, "R1 reset count");
        lane_state_i = 24'hA5C3E1;
        snap_sel_i = 1'b1;
        check_word(24'h000000, "R1 reset snapshot");
        rst_n = 1'b1;

        // R7: live view with layout (lane 5 = DP tx3 in bits 23:20)
        snap_sel_i = 1'b0;
        check_word(24'hA5C3E1, "R7 live word");
        lane_state_i = 24'h800001;
        check_word(24'h800001, "R7 lane0 pstate and lane5 ack bits");

        // R2: several multipliers
        req_and_check(0, 1, "R2 m0 n1");
        req_and_check(0, 10, "R2 m0 n10");
        req_and_check(3, 100, "R2 m3 n100");
        req_and_check(5, 31, "R2 m5 below one period");
        req_and_check(5, 64, "R2 m5 n64");

        // R4: hold after done, stray done and timeout while idle
        repeat (20) @(negedge clk);
        expect_result(16'd2, 1'b0, "R4 held after done");
        done_i = 1'b1;
        @(negedge clk);
        done_i = 1'b0;
        timeout_i = 1'b1;
        @(negedge clk);
        timeout_i = 1'b0;
        expect_result(16'd2, 1'b0, "R4 idle done/timeout ignored");

        // R3: multiplier sampled at start
        run_req(2, 20, 1'b0, 0);
        expect_result(16'd5, 1'b0, "R3 mult latched at start");

        // R6: restart while open
        @(negedge clk);
        start_i = 1'b1;
        mult_i = 5'd0;
        @(negedge clk);
        start_i = 1'b0;
        repeat (50) @(negedge clk);
        run_req(0, 7, 1'b0, 0);
        expect_result(16'd7, 1'b0, "R6 restart from zero");

        // R8: timeout captures the live word
        lane_state_i = 24'h3C96A5;
        run_req(2, 40, 1'b1, 2);
        expect_result(16'd10, 1'b0, "R8 timeout freezes count");
        lane_state_i = 24'h123456;
        snap_sel_i = 1'b1;
        check_word(24'h3C96A5, "R8 captured word");
        snap_sel_i = 1'b0;
        check_word(24'h123456, "R7 live after capture");
        lane_state_i = 24'hFFFFFF;
        timeout_i = 1'b1;
        @(negedge clk);
        timeout_i = 1'b0;
        snap_sel_i = 1'b1;
        check_word(24'h3C96A5, "R8 idle timeout no capture");
        snap_sel_i = 1'b0;

        // R5: saturation boundary
        req_and_check(0, 65535, "R5 exact full count");
        req_and_check(0, 65536, "R5 overrun");
        repeat (5) @(negedge clk);
        expect_result(16'hFFFF, 1'b1, "R5 overrun sticky");
        req_and_check(0, 5, "R5 cleared by start");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule